// File: doc/BRIEF.md
# ADC Auto-Trigger Source Selector

This block decides when an analog-to-digital converter should start a conversion without software asking for it. A 3-bit select code picks one of eight trigger sources. Code 0 is free-running: the converter restarts itself each time a conversion completes. Codes 1 to 7 each pick one of seven event-flag levels that other peripherals produce. The block turns a rising edge of the chosen level into a single-cycle start pulse for the conversion sequencer.

Two enables gate the pulse: the auto-trigger enable and the converter enable. A busy input from the sequencer blocks new starts while a conversion runs. Any edge that arrives during that time is dropped, not queued. Edge detection runs on the output of the multiplexer, so changing the select code alone can produce a start. The one exception is a switch into free-running, which never produces one.

Top module: `adc_trig_select`

## Requirements
- R1: Select code k in 1..7 routes event flag bit k-1 (`evt_flags[k-1]`) to the edge detector. Code 0 routes `conv_done`.
- R2: A rising edge of the selected level, with both enables high and `conv_busy` low, raises `start_pulse` for exactly one cycle, in the clock cycle after the edge. A level that stays high gives no further pulses.
- R3: Changing `src_sel` from a source whose level is low to a source whose level is high counts as a rising edge and produces a pulse.
- R4: A change of `src_sel` into code 0 never produces a pulse, even when `conv_done` is already high.
- R5: While `auto_en` is low, no pulse is produced, whatever the select code and the flags do.
- R6: While `adc_en` is low, no pulse is produced.
- R7: In free-running mode (code 0), each completed conversion starts the next one. Completion means either `conv_busy` falling or `conv_done` rising, and either gives one pulse in the next cycle.
- R8: A rising edge seen while `conv_busy` is high is ignored. No pulse follows when `conv_busy` later drops, unless a new edge arrives.
- R9: The stored previous level follows the multiplexer output every cycle, even while the block is disabled. A level that rose while disabled therefore gives no pulse when the block is enabled again.
- R10: During and right after reset, `start_pulse` is low.
- R11: Edges on event flags that are not selected produce no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| evt_flags | input | NUM_SRC-1 | Event-flag levels; bit k-1 is the source for code k |
| conv_done | input | 1 | Conversion-complete flag of the converter |
| src_sel | input | SEL_W | Trigger source code; 0 selects free-running |
| auto_en | input | 1 | Auto-trigger enable |
| adc_en | input | 1 | Converter enable |
| conv_busy | input | 1 | High while a conversion is in progress |
| start_pulse | output | 1 | One-cycle conversion start request |

## Verification
The scoreboard walks every select code with an isolated edge, so a design that maps the code to the wrong flag bit pulses in the wrong step. It switches from a low source to a high source to catch designs that detect edges per source: such a design misses that start. It also switches into free-running while the done flag is high, which catches designs that fire on that switch. Other steps raise a flag while the block is busy or disabled and then release the block. A design that queues edges, or stops updating the previous level while disabled, gives a late pulse there.

// File: rtl/adc_trig_pkg.sv
package adc_trig_pkg;
   // Code that selects the converter's own completion flag (free-running).
   localparam int unsigned FREE_RUN_CODE = 0;

   function automatic logic rose(input logic now_v, input logic was_v);
      return now_v & ~was_v;
   endfunction
endpackage

// File: rtl/trig_src_mux.sv
module trig_src_mux #(
   parameter int unsigned NUM_SRC = 8,
   parameter int unsigned SEL_W   = 3
) (
   input  logic [NUM_SRC-2:0] evt_flags,
   input  logic               conv_done,
   input  logic [SEL_W-1:0]   src_sel,
   output logic               src_lvl
);
   localparam int unsigned SLOTS = 1 << SEL_W;

   logic [SLOTS-1:0] slot_v;

   generate
      for (genvar i = 0; i < SLOTS; i++) begin : g_slot
         if (i == adc_trig_pkg::FREE_RUN_CODE) begin : g_free
            assign slot_v[i] = conv_done;
         end else if (i < NUM_SRC) begin : g_evt
            assign slot_v[i] = evt_flags[i-1];
         end else begin : g_pad
            assign slot_v[i] = 1'b0;
         end
      end
   endgenerate

   assign src_lvl = slot_v[src_sel];
endmodule

// File: rtl/trig_edge_det.sv
module trig_edge_det #(
   parameter int unsigned SEL_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             src_lvl,
   input  logic [SEL_W-1:0] src_sel,
   output logic             lvl_rise,
   output logic             enter_free
);
   localparam logic [SEL_W-1:0] FREE_SEL = SEL_W'(adc_trig_pkg::FREE_RUN_CODE);

   logic             lvl_q;
   logic [SEL_W-1:0] sel_q;

   // The previous level and code follow the inputs every cycle, whatever the enables are.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lvl_q <= 1'b0;
         sel_q <= FREE_SEL;
      end else begin
         lvl_q <= src_lvl;
         sel_q <= src_sel;
      end
   end

   assign lvl_rise   = adc_trig_pkg::rose(src_lvl, lvl_q);
   assign enter_free = (src_sel == FREE_SEL) && (sel_q != FREE_SEL);
endmodule

// File: rtl/trig_gate.sv
module trig_gate #(
   parameter bit OUT_REG = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic lvl_rise,
   input  logic enter_free,
   input  logic sel_free,
   input  logic conv_busy,
   input  logic auto_en,
   input  logic adc_en,
   output logic start_pulse
);
   logic busy_q;
   logic busy_fall;
   logic fire;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) busy_q <= 1'b0;
      else        busy_q <= conv_busy;
   end

   assign busy_fall = busy_q & ~conv_busy;

   always_comb begin
      fire = 1'b0;
      if (auto_en && adc_en && !conv_busy) begin
         fire = (lvl_rise && !enter_free) || (sel_free && busy_fall);
      end
   end

   generate
      if (OUT_REG) begin : g_reg
         logic fire_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) fire_q <= 1'b0;
            else        fire_q <= fire;
         end
         assign start_pulse = fire_q;
      end else begin : g_comb
         assign start_pulse = fire;
      end
   endgenerate
endmodule

// File: rtl/adc_trig_select.sv
module adc_trig_select #(
   parameter int unsigned NUM_SRC = 8,
   parameter bit          OUT_REG = 1'b1,
   parameter int unsigned SEL_W   = $clog2(NUM_SRC)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-2:0] evt_flags,
   input  logic               conv_done,
   input  logic [SEL_W-1:0]   src_sel,
   input  logic               auto_en,
   input  logic               adc_en,
   input  logic               conv_busy,
   output logic               start_pulse
);
   localparam logic [SEL_W-1:0] FREE_SEL = SEL_W'(adc_trig_pkg::FREE_RUN_CODE);

   generate
      if (NUM_SRC < 2) begin : g_bad_num
         $error("NUM_SRC must be at least 2");
      end
      if ((1 << SEL_W) < NUM_SRC) begin : g_bad_sel
         $error("SEL_W too narrow for NUM_SRC");
      end
   endgenerate

   logic src_lvl;
   logic lvl_rise;
   logic enter_free;

   trig_src_mux #(.NUM_SRC(NUM_SRC), .SEL_W(SEL_W)) u_mux (
      .evt_flags (evt_flags),
      .conv_done (conv_done),
      .src_sel   (src_sel),
      .src_lvl   (src_lvl)
   );

   trig_edge_det #(.SEL_W(SEL_W)) u_edge (
      .clk        (clk),
      .rst_n      (rst_n),
      .src_lvl    (src_lvl),
      .src_sel    (src_sel),
      .lvl_rise   (lvl_rise),
      .enter_free (enter_free)
   );

   trig_gate #(.OUT_REG(OUT_REG)) u_gate (
      .clk         (clk),
      .rst_n       (rst_n),
      .lvl_rise    (lvl_rise),
      .enter_free  (enter_free),
      .sel_free    (src_sel == FREE_SEL),
      .conv_busy   (conv_busy),
      .auto_en     (auto_en),
      .adc_en      (adc_en),
      .start_pulse (start_pulse)
   );
endmodule

// File: rtl/adc_trig_select_chk.sv
module adc_trig_select_chk #(
   parameter int unsigned NUM_SRC = 8,
   parameter int unsigned SEL_W   = $clog2(NUM_SRC)
) (
   input logic               clk,
   input logic               rst_n,
   input logic [NUM_SRC-2:0] evt_flags,
   input logic               conv_done,
   input logic [SEL_W-1:0]   src_sel,
   input logic               auto_en,
   input logic               adc_en,
   input logic               conv_busy,
   input logic               start_pulse
);
   logic picked;
   always_comb begin
      picked = 1'b0;
      if (src_sel == '0) picked = conv_done;
      for (int k = 1; k < NUM_SRC; k++) begin
         if (int'(src_sel) == k) picked = evt_flags[k-1];
      end
   end

   // R2
   a_r2_edge_fires: assert property (@(posedge clk) disable iff (!rst_n)
      (auto_en && adc_en && !conv_busy && src_sel != '0 && $stable(src_sel)
       && picked && !$past(picked)) |=> start_pulse);
   // R4
   a_r4_free_entry_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (src_sel == '0 && $past(src_sel) != '0 && !($past(conv_busy) && !conv_busy))
      |=> !start_pulse);
   // R5
   a_r5_auto_off_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !auto_en |=> !start_pulse);
   // R6
   a_r6_adc_off_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !adc_en |=> !start_pulse);
   // R8
   a_r8_busy_blocks: assert property (@(posedge clk) disable iff (!rst_n)
      conv_busy |=> !start_pulse);
endmodule

bind adc_trig_select adc_trig_select_chk #(.NUM_SRC(NUM_SRC), .SEL_W(SEL_W)) u_chk (.*);

// File: tb/tb_adc_trig_select.sv
module tb_adc_trig_select;
   localparam int unsigned NSRC = 8;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic [NSRC-2:0] evt_flags = '0;
   logic            conv_done = 1'b0;
   logic [2:0]      src_sel = 3'd0;
   logic            auto_en = 1'b0;
   logic            adc_en = 1'b0;
   logic            conv_busy = 1'b0;
   logic            start_pulse;

   int cyc = 0;
   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   int    q_due[$];
   bit    q_exp[$];
   string q_tag[$];

   always #2.5 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   adc_trig_select #(.NUM_SRC(NSRC)) dut (
      .clk(clk), .rst_n(rst_n), .evt_flags(evt_flags), .conv_done(conv_done),
      .src_sel(src_sel), .auto_en(auto_en), .adc_en(adc_en),
      .conv_busy(conv_busy), .start_pulse(start_pulse)
   );

   // Driver: the inputs set before the call are held for one clock; the expected pulse follows one clock later.
   task automatic step(input bit exp, input string tag);
      q_due.push_back(cyc + 1);
      q_exp.push_back(exp);
      q_tag.push_back(tag);
      @(posedge clk);
      #1;
   endtask

   // Monitor
   always @(negedge clk) begin
      if (q_due.size() > 0 && q_due[0] == cyc) begin
         bit    e;
         string t;
         void'(q_due.pop_front());
         e = q_exp.pop_front();
         t = q_tag.pop_front();
         checks++;
         if (start_pulse !== e) begin
            errors++;
            $display("FAIL %s: start_pulse=%b expected=%b (cycle %0d)", t, start_pulse, e, cyc);
         end
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         errors++;
         checks++;
         $display("FAIL watchdog: run incomplete, actual=hung expected=done");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      @(posedge clk); #1;
      step(0, "R10 in reset");
      step(0, "R10 in reset");
      rst_n = 1'b1;
      step(0, "R10 after reset");
      auto_en = 1'b1; adc_en = 1'b1; src_sel = 3'd1;
      step(0, "R10 idle");
      // R2: single pulse, held level quiet
      evt_flags[0] = 1'b1; step(1, "R2 edge");
      step(0, "R2 held level");
      step(0, "R2 held level");
      evt_flags[0] = 1'b0; step(0, "R2 fall");
      // R11: unselected flag
      evt_flags[3] = 1'b1; step(0, "R11 unselected");
      evt_flags[3] = 1'b0; step(0, "R11 unselected");
      // R1: every event code
      for (int k = 1; k < 8; k++) begin
         src_sel = 3'(k); evt_flags = '0;
         step(0, "R1 setup");
         evt_flags[k-1] = 1'b1; step(1, $sformatf("R1 code %0d", k));
         evt_flags = '0; step(0, "R1 clear");
      end
      // R3: select change from low to high source
      src_sel = 3'd2; evt_flags = 7'b0000100;
      step(0, "R3 low source");
      src_sel = 3'd3; step(1, "R3 switch to high");
      src_sel = 3'd2; step(0, "R3 back to low");
      src_sel = 3'd3; step(1, "R3 switch again");
      evt_flags = '0; src_sel = 3'd1; step(0, "R3 clear");
      // R4: entering free-running with done high
      conv_done = 1'b1; step(0, "R4 setup");
      src_sel = 3'd0; step(0, "R4 entry quiet");
      step(0, "R4 steady");
      conv_done = 1'b0; step(0, "R7 done low");
      // R7: completion in free-running
      conv_done = 1'b1; step(1, "R7 done rise");
      conv_done = 1'b0; step(0, "R7 after");
      conv_busy = 1'b1; step(0, "R7 busy");
      step(0, "R7 busy");
      conv_busy = 1'b0; step(1, "R7 busy fall");
      step(0, "R7 single pulse");
      // R8: busy blocks, no queueing; busy fall outside free mode is quiet
      src_sel = 3'd1; step(0, "R8 setup");
      conv_busy = 1'b1; evt_flags[0] = 1'b1; step(0, "R8 edge while busy");
      conv_busy = 1'b0; step(0, "R8 not queued");
      step(0, "R8 not queued");
      evt_flags[0] = 1'b0; step(0, "R8 clear");
      // R5 then R9: edge while auto off, then re-enable
      auto_en = 1'b0; evt_flags[0] = 1'b1; step(0, "R5 auto off");
      auto_en = 1'b1; step(0, "R9 stale edge after auto on");
      evt_flags[0] = 1'b0; step(0, "R5 clear");
      // R6 then R9
      adc_en = 1'b0; evt_flags[0] = 1'b1; step(0, "R6 adc off");
      adc_en = 1'b1; step(0, "R9 stale edge after adc on");
      evt_flags[0] = 1'b0; step(0, "R6 clear");
      // R5: select change to high source while auto off
      auto_en = 1'b0; evt_flags[1] = 1'b1; src_sel = 3'd2; step(0, "R5 switch while off");
      auto_en = 1'b1; step(0, "R9 enable after switch");
      evt_flags = '0; step(0, "R9 clear");
      evt_flags[1] = 1'b1; step(1, "R2 edge after re-enable");
      evt_flags = '0; step(0, "R2 end");
      step(0, "drain");
      wait (q_due.size() == 0);
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule